// File: doc/BRIEF.md
# Bit-Serial Adder with Registered Sum Bit

This block adds two unsigned binary numbers one bit position per clock. Each cycle with the enable strobe high, it takes one bit from each operand, least significant position first. A full adder combines that pair with the carry held from the previous position. On the same rising edge, the new carry and the resulting sum bit are both loaded into flip-flops.

Because the sum bit is registered on the edge that updates the carry, the output stays correct for the whole following cycle. Without that register, the output would show the fresh carry combined with the old operand bits, which is the wrong value.

A synchronous clear starts each new addition. The held carry is exposed as a flag. Once the most significant pair has been consumed, that flag is the unsigned overflow of the whole sum. A valid output marks each cycle in which the sum output holds a freshly produced bit.

Top module: `sadd_top`

## Requirements
- R1: Operand bits enter least significant position first, one pair per clock edge with `en` high. The sum bits, collected in the order they appear, form (a + b) mod 2^N for N-bit operands.
- R2: After an edge with `en` high and `clr` low, `carry_flag` equals the majority of `a_bit`, `b_bit` and the previous `carry_flag`. It is 1 when two or more of these three are 1.
- R3: After an edge with `en` high and `clr` low, `sum_bit` equals the XOR of `a_bit`, `b_bit` and the previous `carry_flag`. It is registered on that same edge.
- R4: After an edge with `en` low and `clr` low, `sum_bit` and `carry_flag` keep their previous values.
- R5: After an edge with `clr` high, `carry_flag`, `sum_bit` and `sum_vld` are all 0, whatever the value of `en` or the operand bits.
- R6: After an edge with `clr` low, `sum_vld` equals the value `en` had at that edge.
- R7: After the most significant pair of an addition, `carry_flag` equals bit N of a + b, which is the unsigned overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| clr | input | 1 | Synchronous clear; takes priority over `en` |
| en | input | 1 | Consume one operand bit pair on this edge |
| a_bit | input | 1 | Serial bit of operand A, LSB first |
| b_bit | input | 1 | Serial bit of operand B, LSB first |
| sum_bit | output | 1 | Registered serial sum bit |
| sum_vld | output | 1 | `sum_bit` holds a bit produced on the last edge |
| carry_flag | output | 1 | Held carry; the overflow flag after the last pair |

## Verification
Every result of this block is due exactly one rising edge after its operand pair is sampled. That result is the sum bit, the carry flag and the valid flag. The bench drives inputs on the falling edge and samples outputs on the following falling edge, which lies half a period after the edge that produced them.

The scoreboard queues one expected sum/carry pair per enabled cycle and pops it only when `sum_vld` is seen high. Idle and clear cycles therefore never shift the alignment. Hold checks are taken on the falling edge after an idle edge. Whole-word and overflow checks are taken two falling edges after the last pair, once the monitor has recorded the final bit.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

    typedef struct packed {
        logic carry;
        logic sum;
        logic vld;
    } sadd_state_t;

    localparam sadd_state_t SADD_CLEARED = '{carry: 1'b0, sum: 1'b0, vld: 1'b0};

endpackage

// File: rtl/sadd_fa.sv
module sadd_fa (
    input  logic x_i,
    input  logic y_i,
    input  logic ci_i,
    output logic s_o,
    output logic co_o
);
    always_comb begin
        s_o  = x_i ^ y_i ^ ci_i;
        co_o = (x_i & y_i) | (x_i & ci_i) | (y_i & ci_i);
    end
endmodule

// File: rtl/sadd_top.sv
module sadd_top
    import sadd_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic en,
    input  logic a_bit,
    input  logic b_bit,
    output logic sum_bit,
    output logic sum_vld,
    output logic carry_flag
);
    sadd_state_t st_d, st_q;
    logic        fa_s, fa_co;

    sadd_fa u_fa (
        .x_i  (a_bit),
        .y_i  (b_bit),
        .ci_i (st_q.carry),
        .s_o  (fa_s),
        .co_o (fa_co)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (clr) begin
            st_d = SADD_CLEARED;
        end else if (en) begin
            st_d.carry = fa_co;
            st_d.sum   = fa_s;
            st_d.vld   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sum_bit    = st_q.sum;
    assign sum_vld    = st_q.vld;
    assign carry_flag = st_q.carry;
endmodule

// File: rtl/sadd_chk.sv
module sadd_chk (
    input logic clk,
    input logic clr,
    input logic en,
    input logic a_bit,
    input logic b_bit,
    input logic sum_bit,
    input logic sum_vld,
    input logic carry_flag
);
    logic seen_q = 1'b0;
    logic clr_q  = 1'b0;

    always_ff @(posedge clk) begin
        if (clr) seen_q <= 1'b1;
        clr_q <= clr;
    end

    // R2
    assert_carry_major_R2: assert property (@(posedge clk) disable iff (clr || !seen_q)
        en |=> carry_flag == (($past(a_bit) & $past(b_bit)) |
                              ($past(a_bit) & $past(carry_flag)) |
                              ($past(b_bit) & $past(carry_flag))));

    // R3
    assert_sum_xor_R3: assert property (@(posedge clk) disable iff (clr || !seen_q)
        en |=> sum_bit == ($past(a_bit) ^ $past(b_bit) ^ $past(carry_flag)));

    // R4
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (clr || !seen_q)
        !en |=> $stable(sum_bit) && $stable(carry_flag));

    // R5
    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!seen_q)
        clr_q |-> !carry_flag && !sum_bit && !sum_vld);

    // R6
    assert_vld_follows_R6: assert property (@(posedge clk) disable iff (clr || !seen_q)
        1'b1 |=> sum_vld == $past(en));
endmodule

bind sadd_top sadd_chk u_chk (.*);

// File: tb/tb_sadd_top.sv
module tb_sadd_top;
    localparam int W = 8;

    typedef struct packed {
        logic s;
        logic c;
    } exp_t;

    logic clk = 1'b0;
    logic clr = 1'b0;
    logic en = 1'b0;
    logic a_bit = 1'b0;
    logic b_bit = 1'b0;
    logic sum_bit, sum_vld, carry_flag;

    int checks = 0;
    int fails = 0;
    exp_t q[$];
    logic [W-1:0] got_word;
    int got_idx = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    sadd_top dut (
        .clk(clk), .clr(clr), .en(en), .a_bit(a_bit), .b_bit(b_bit),
        .sum_bit(sum_bit), .sum_vld(sum_vld), .carry_flag(carry_flag)
    );

    task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // monitor: pops one expected item per valid sum bit
    always @(negedge clk) begin
        if (sum_vld === 1'b1) begin
            if (q.size() == 0) begin
                check("R6", {{W{1'b0}}, 1'b1}, {(W+1){1'b0}});
            end else begin
                exp_t e;
                e = q.pop_front();
                check("R3", {{W{1'b0}}, sum_bit}, {{W{1'b0}}, e.s});
                check("R2", {{W{1'b0}}, carry_flag}, {{W{1'b0}}, e.c});
                if (got_idx < W) got_word[got_idx] = sum_bit;
                got_idx++;
            end
        end
    end

    task automatic add_word(input logic [W-1:0] a, input logic [W-1:0] b, input bit gaps);
        logic mc;
        logic last_s;
        logic [W:0] ref_sum;
        // clear with en and operand bits high to show clear priority
        @(negedge clk);
        clr = 1'b1; en = 1'b1; a_bit = 1'b1; b_bit = 1'b1;
        @(negedge clk);
        clr = 1'b0; en = 1'b0;
        check("R5", {{(W-2){1'b0}}, carry_flag, sum_bit, sum_vld}, {(W+1){1'b0}});
        got_idx = 0; got_word = '0; mc = 1'b0; last_s = 1'b0;
        for (int i = 0; i < W; i++) begin
            a_bit = a[i]; b_bit = b[i]; en = 1'b1;
            last_s = a[i] ^ b[i] ^ mc;
            mc = (a[i] & b[i]) | (a[i] & mc) | (b[i] & mc);
            q.push_back('{s: last_s, c: mc});
            @(negedge clk);
            if (gaps && ($urandom_range(0, 2) == 0)) begin
                en = 1'b0; a_bit = ~a_bit; b_bit = ~b_bit;
                @(negedge clk);
                // R4: idle edge keeps sum and carry
                check("R4", {{(W-1){1'b0}}, sum_bit, carry_flag}, {{(W-1){1'b0}}, last_s, mc});
                check("R6", {{W{1'b0}}, sum_vld}, {(W+1){1'b0}});
            end
        end
        en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        ref_sum = {1'b0, a} + {1'b0, b};
        check("R1", {1'b0, got_word}, {1'b0, ref_sum[W-1:0]});
        check("R7", {{W{1'b0}}, carry_flag}, {{W{1'b0}}, ref_sum[W]});
    endtask

    initial begin
        add_word('1, '1, 1'b0);
        add_word('0, '0, 1'b0);
        add_word('1, {{(W-1){1'b0}}, 1'b1}, 1'b0);
        add_word({W/2{2'b10}}, {W/2{2'b01}}, 1'b1);
        for (int n = 0; n < 30; n++) begin
            add_word(W'($urandom), W'($urandom), n[0]);
        end
        add_word('1, '1, 1'b1);
        check("R1", {{W{1'b0}}, 1'b0}, {(W+1){1'b0}} + W'(q.size()));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule